// File: doc/BRIEF.md
# E1 Transmit Frame Timing Generator

This block keeps the bit, timeslot and frame position of an E1 transmit stream. It counts bit clocks into 8-bit timeslots, timeslots into 32-slot frames, and frames into 16-frame multiframes. It also tracks whether the current frame is an alignment frame or a non-alignment frame. Other parts of the transmit path read these counters and markers to decide what to place in each bit position.

Two sync inputs set the phase: a frame sync and a multiframe sync. Each input rises one bit clock before the boundary it marks. On the clock edge that first samples a rising input, the block reloads its counters, so the following cycle shows bit 0 of timeslot 0. When the counters already sit on the last bit of a frame, the reload gives the same values as counting on, so an edge in the expected place changes nothing.

A mode input selects the multiframe phasing. In CRC4 phasing the multiframe always begins with an alignment frame. In CAS phasing the alignment alternation keeps its own phase across a multiframe reload. With no sync edges, the counters run freely from reset.

Top module: `e1_tx_timing`

## Requirements
- R1: While reset is held and right after it is released, the outputs show bit 0, timeslot 0, frame 0, align_frame_o=1, mf_start_o=1 and frame_start_o=1.
- R2: With no new rising edge on a sync input, bit_o counts 0..7 and then wraps. slot_o advances 0..31 when bit_o wraps. frame_o advances 0..15 when slot_o wraps, so one frame lasts 256 clocks.
- R3: Without a sync edge, align_frame_o inverts only on the clock that starts a new frame (bit 0, timeslot 0) and keeps its value on every other clock.
- R4: A clock edge that samples fsync_i high after it was sampled low (and that sees no multiframe rise) produces bit 0 and timeslot 0 on the next cycle. On that cycle frame_o is the previous frame plus 1 (modulo 16) and align_frame_o is inverted.
- R5: A clock edge that sees a rise of mfsync_i while crc4_mode_i=1 produces bit 0, timeslot 0, frame 0 and align_frame_o=1 on the next cycle.
- R6: A clock edge that sees a rise of mfsync_i while crc4_mode_i=0 (CAS) produces bit 0, timeslot 0 and frame 0 on the next cycle, with align_frame_o inverted from its previous value.
- R7: A sync rise sampled while the counters are at timeslot 31, bit 7 (and, for the multiframe sync, frame 15 with a consistent align phase) leaves the output sequence the same as free running.
- R8: A sync input held high after its rise has no further effect; the counters run freely.
- R9: When both sync inputs rise on the same clock, the multiframe reload wins.
- R10: mf_start_o is high exactly during frame 0. frame_start_o is high exactly during bit 0 of timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; rises one clock before a frame boundary |
| mfsync_i | input | 1 | Multiframe sync; rises one clock before a multiframe boundary |
| crc4_mode_i | input | 1 | 1 = CRC4 multiframe phasing, 0 = CAS phasing |
| bit_o | output | 3 | Bit index within the timeslot |
| slot_o | output | 5 | Timeslot index within the frame |
| frame_o | output | 4 | Frame index within the multiframe |
| align_frame_o | output | 1 | High during an alignment frame |
| mf_start_o | output | 1 | High during the first frame of the multiframe |
| frame_start_o | output | 1 | High during the first bit of a frame |

## Verification
On every cycle the assertions check the single-step counting rules: the bit stepping, the slot holding inside a timeslot, the align level staying steady away from frame ends, and the reload results after each kind of sync rise, in both phasing modes. Some behaviour only shows up over the bench's longer runs: an aligned sync edge leaving the stream undisturbed, a sync input held high having no further effect, and both sync inputs rising on the same clock. The bench's scenarios also cover the full frame and multiframe wrap over hundreds of cycles and mode changes mixed with random sync traffic.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam int unsigned DEF_NUM_SLOTS = 32;
  localparam int unsigned DEF_MF_FRAMES = 16;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_FRAME = 2'd1,
    EV_MULTI = 2'd2
  } sync_ev_e;
endpackage

// File: rtl/e1_tx_sync_edge.sv
module e1_tx_sync_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= sync_i[i];
    end
    assign rise_o[i] = sync_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/e1_tx_pos_cnt.sv
module e1_tx_pos_cnt #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned BW = $clog2(SLOT_BITS),
  localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  output logic [BW-1:0] bit_o,
  output logic [SW-1:0] slot_o,
  output logic          last_o
);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_SLOTS - 1);

  logic [BW-1:0] bit_q;
  logic [SW-1:0] slot_q;
  logic          bit_end;

  assign bit_end = (bit_q == BIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (reload_i) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (bit_end) begin
      bit_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      bit_q  <= bit_q + 1'b1;
    end
  end

  assign bit_o  = bit_q;
  assign slot_o = slot_q;
  assign last_o = bit_end & (slot_q == SLOT_LAST);
endmodule

// File: rtl/e1_tx_frame_seq.sv
module e1_tx_frame_seq #(
  parameter int unsigned MF_FRAMES = 16,
  localparam int unsigned FW = $clog2(MF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  e1_tx_pkg::sync_ev_e ev_i,
  input  logic          wrap_i,
  input  logic          crc4_i,
  output logic [FW-1:0] frame_o,
  output logic          align_o
);
  import e1_tx_pkg::*;

  localparam logic [FW-1:0] FRAME_LAST = FW'(MF_FRAMES - 1);

  logic [FW-1:0] frame_q;
  logic          align_q;
  logic          adv;

  // frame sync rise or natural end of frame
  assign adv = (ev_i == EV_FRAME) | ((ev_i == EV_NONE) & wrap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      align_q <= 1'b1;
    end else if (ev_i == EV_MULTI) begin
      frame_q <= '0;
      // CRC4: multiframe starts on an alignment frame; CAS: alternation keeps its phase
      align_q <= crc4_i ? 1'b1 : ~align_q;
    end else if (adv) begin
      frame_q <= (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
      align_q <= ~align_q;
    end
  end

  assign frame_o = frame_q;
  assign align_o = align_q;
endmodule

// File: rtl/e1_tx_timing.sv
module e1_tx_timing #(
  parameter int unsigned SLOT_BITS = e1_tx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = e1_tx_pkg::DEF_NUM_SLOTS,
  parameter int unsigned MF_FRAMES = e1_tx_pkg::DEF_MF_FRAMES,
  localparam int unsigned BW = $clog2(SLOT_BITS),
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned FW = $clog2(MF_FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fsync_i,
  input  logic          mfsync_i,
  input  logic          crc4_mode_i,
  output logic [BW-1:0] bit_o,
  output logic [SW-1:0] slot_o,
  output logic [FW-1:0] frame_o,
  output logic          align_frame_o,
  output logic          mf_start_o,
  output logic          frame_start_o
);
  import e1_tx_pkg::*;

  logic [1:0] rise;
  logic       wrap;
  sync_ev_e   ev;

  e1_tx_sync_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i ({mfsync_i, fsync_i}),
    .rise_o (rise)
  );

  // multiframe sync has priority
  always_comb begin
    if (rise[1])      ev = EV_MULTI;
    else if (rise[0]) ev = EV_FRAME;
    else              ev = EV_NONE;
  end

  e1_tx_pos_cnt #(
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (ev != EV_NONE),
    .bit_o    (bit_o),
    .slot_o   (slot_o),
    .last_o   (wrap)
  );

  e1_tx_frame_seq #(
    .MF_FRAMES (MF_FRAMES)
  ) u_frm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .wrap_i  (wrap),
    .crc4_i  (crc4_mode_i),
    .frame_o (frame_o),
    .align_o (align_frame_o)
  );

  assign mf_start_o    = (frame_o == '0);
  assign frame_start_o = (bit_o == '0) & (slot_o == '0);
endmodule

// File: rtl/e1_tx_timing_chk.sv
module e1_tx_timing_chk #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned MF_FRAMES = 16,
  localparam int unsigned BW = $clog2(SLOT_BITS),
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned FW = $clog2(MF_FRAMES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fsync_i,
  input logic          mfsync_i,
  input logic          crc4_mode_i,
  input logic [BW-1:0] bit_o,
  input logic [SW-1:0] slot_o,
  input logic [FW-1:0] frame_o,
  input logic          align_frame_o,
  input logic          mf_start_o
);
  localparam logic [BW-1:0] BL = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SL = SW'(NUM_SLOTS - 1);

  logic fs_q, mf_q, fr, mr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q <= 1'b0;
      mf_q <= 1'b0;
    end else begin
      fs_q <= fsync_i;
      mf_q <= mfsync_i;
    end
  end

  assign fr = fsync_i & ~fs_q;
  assign mr = mfsync_i & ~mf_q;

  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fr && !mr) |=> bit_o == BW'($past(bit_o) + 1'b1));

  // R2
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fr && !mr && bit_o != BL) |=> $stable(slot_o));

  // R3
  align_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fr && !mr && !(bit_o == BL && slot_o == SL)) |=> $stable(align_frame_o));

  // R4
  fsync_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr && !mr) |=> (bit_o == '0 && slot_o == '0 &&
                     frame_o == FW'($past(frame_o) + 1'b1) &&
                     align_frame_o != $past(align_frame_o)));

  // R5
  mf_crc4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr && crc4_mode_i) |=> (bit_o == '0 && slot_o == '0 && frame_o == '0 && align_frame_o));

  // R6
  mf_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr && !crc4_mode_i) |=> (frame_o == '0 && bit_o == '0 && align_frame_o != $past(align_frame_o)));

  // R10
  mf_mark_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mf_start_o) |-> (bit_o == '0 && slot_o == '0));
endmodule

bind e1_tx_timing e1_tx_timing_chk #(
  .SLOT_BITS (SLOT_BITS),
  .NUM_SLOTS (NUM_SLOTS),
  .MF_FRAMES (MF_FRAMES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fsync_i       (fsync_i),
  .mfsync_i      (mfsync_i),
  .crc4_mode_i   (crc4_mode_i),
  .bit_o         (bit_o),
  .slot_o        (slot_o),
  .frame_o       (frame_o),
  .align_frame_o (align_frame_o),
  .mf_start_o    (mf_start_o)
);

// File: tb/e1_tx_timing_tb.sv
`timescale 1ns/1ps
module e1_tx_timing_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fsync_i = 1'b0;
  logic mfsync_i = 1'b0;
  logic crc4_mode_i = 1'b1;
  logic [2:0] bit_o;
  logic [4:0] slot_o;
  logic [3:0] frame_o;
  logic align_frame_o, mf_start_o, frame_start_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  e1_tx_timing u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i), .mfsync_i(mfsync_i),
    .crc4_mode_i(crc4_mode_i), .bit_o(bit_o), .slot_o(slot_o), .frame_o(frame_o),
    .align_frame_o(align_frame_o), .mf_start_o(mf_start_o), .frame_start_o(frame_start_o)
  );

  // reference model from the requirements
  logic [2:0] m_bit;
  logic [4:0] m_slot;
  logic [3:0] m_frame;
  logic m_align, m_fs_q, m_mf_q;
  string m_tag = "R1";

  function automatic logic [11:0] pack_pos(logic [2:0] b, logic [4:0] s, logic [3:0] f);
    return {f, s, b};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_bit = 0; m_slot = 0; m_frame = 0; m_align = 1; m_fs_q = 0; m_mf_q = 0; m_tag = "R1";
    end else begin
      logic fr, mr;
      fr = fsync_i & ~m_fs_q;
      mr = mfsync_i & ~m_mf_q;
      m_fs_q = fsync_i;
      m_mf_q = mfsync_i;
      if (mr) begin
        m_tag = crc4_mode_i ? "R5" : "R6";
        m_bit = 0; m_slot = 0; m_frame = 0;
        m_align = crc4_mode_i ? 1'b1 : ~m_align;
      end else if (fr) begin
        m_tag = "R4";
        m_bit = 0; m_slot = 0; m_frame = m_frame + 1; m_align = ~m_align;
      end else if (m_bit == 7 && m_slot == 31) begin
        m_tag = "R3";
        m_bit = 0; m_slot = 0; m_frame = m_frame + 1; m_align = ~m_align;
      end else begin
        m_tag = "R2";
        if (m_bit == 7) begin m_bit = 0; m_slot = m_slot + 1; end
        else m_bit = m_bit + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {19'd0, align_frame_o, pack_pos(bit_o, slot_o, frame_o)},
             {19'd0, m_align, pack_pos(m_bit, m_slot, m_frame)});
    chk("R10", {30'd0, mf_start_o, frame_start_o},
               {30'd0, (m_frame == 0), (m_bit == 0 && m_slot == 0)});
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'hE1A5);
    repeat (3) step();
    // R1
    check_all("R1");
    rst_ni = 1'b1;
    step();
    check_all("R2");

    // R2: full frame of free running
    repeat (255) begin step(); check_all(m_tag); end
    chk("R2", {28'd0, frame_o}, 32'd1);

    // R7: aligned frame sync at slot 31 bit 7
    while (!(m_bit == 7 && m_slot == 31)) step();
    begin
      logic [3:0] f0;
      f0 = frame_o;
      fsync_i = 1'b1;
      step();
      chk("R7", {20'd0, pack_pos(bit_o, slot_o, frame_o)}, {20'd0, pack_pos(3'd0, 5'd0, f0 + 4'd1)});
      check_all("R7");
    end
    // R8: held high, free running continues
    repeat (600) begin step(); check_all("R8"); end
    fsync_i = 1'b0;

    // R7: aligned multiframe sync at frame 15 end in CRC4
    crc4_mode_i = 1'b1;
    while (!(m_bit == 7 && m_slot == 31 && m_frame == 15)) step();
    mfsync_i = 1'b1;
    step();
    chk("R7", {19'd0, align_frame_o, pack_pos(bit_o, slot_o, frame_o)}, {19'd0, 1'b1, 12'd0});
    check_all("R7");
    mfsync_i = 1'b0;

    // R4: misaligned frame sync mid-frame
    repeat (40) step();
    fsync_i = 1'b1; step(); check_all("R4"); fsync_i = 1'b0;

    // R6: CAS multiframe reload mid-frame
    repeat (77) step();
    crc4_mode_i = 1'b0;
    mfsync_i = 1'b1; step(); check_all("R6"); mfsync_i = 1'b0;

    // R9: both rise together in CRC4
    repeat (123) step();
    crc4_mode_i = 1'b1;
    fsync_i = 1'b1; mfsync_i = 1'b1; step();
    chk("R9", {20'd0, pack_pos(bit_o, slot_o, frame_o)}, 32'd0);
    check_all("R9");
    fsync_i = 1'b0; mfsync_i = 1'b0;

    // random sync traffic, both modes
    for (int c = 0; c < 40000; c++) begin
      step();
      check_all(m_tag);
      if (c % 5000 == 0) crc4_mode_i = $urandom_range(0, 1);
      fsync_i  = ($urandom_range(0, 299) == 0) ? 1'b1 : (fsync_i && $urandom_range(0, 3) != 0);
      mfsync_i = ($urandom_range(0, 899) == 0) ? 1'b1 : (mfsync_i && $urandom_range(0, 3) != 0);
    end
    fsync_i = 1'b0; mfsync_i = 1'b0;
    repeat (300) begin step(); check_all(m_tag); end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule